// File: doc/BRIEF.md
# Masked Port Mismatch Detector

This block watches two 8-bit groups of input pins and reports when any selected pin leaves its expected level. For each group, software writes an expected-level register and a select register. A pin takes part in the compare only when its select bit is 1. The two group results are ORed into one level mismatch signal. The compare always uses the raw pin levels, whatever routing the pins are given elsewhere.

The level mismatch sets a sticky interrupt flag, which stays set until a clear pulse. The mismatch is also gated by a wake-enable control bit to form a wake request for low-power modes. Each pin group first passes through a two-flop synchroniser. After that point the mismatch and wake paths are pure logic, so the wake request needs no further clock edge.

The register map uses 3-bit addresses:

| Address | Register |
|---|---|
| 0 | Group 0 expected levels |
| 1 | Group 0 select |
| 2 | Group 1 expected levels |
| 3 | Group 1 select |
| 4 | Control, bit 0 = wake enable |

Top module: `pin_watch_top`

## Requirements
- R1: After reset the select registers read 0x00, the expected-level registers read 0xFF, the control register reads 0x00, and mismatch_o, irq_o and wake_o are 0 for any pin levels.
- R2: A write with wr_en high stores wr_data at address addr (0 = group 0 expected, 1 = group 0 select, 2 = group 1 expected, 3 = group 1 select, 4 = control) on the next clock edge. rd_data is registered: one edge after addr is presented, it shows that register's value.
- R3: mismatch_o is 1 when some group 0 pin whose select bit is 1 differs from its expected-level bit.
- R4: mismatch_o is 1 when some group 1 pin whose select bit is 1 differs from its expected-level bit. The two groups are ORed.
- R5: A pin whose select bit is 0 never causes a mismatch, whatever its level. When all selected pins match, mismatch_o is 0.
- R6: A pin change is seen on mismatch_o after exactly two rising clock edges (the two-flop synchroniser), and on irq_o after three.
- R7: irq_o sets on the edge after any cycle with mismatch_o high. It stays set while clr_i is low, and clears on the edge after a cycle with clr_i high and mismatch_o low.
- R8: If clr_i is high in a cycle where mismatch_o is also high, irq_o stays set.
- R9: wake_o equals mismatch_o ANDed with control bit 0, with no extra clock delay.
- R10: Only bit 0 of the control register is stored; its other bits read 0. Addresses 5 to 7 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin0_i | input | 8 | Group 0 raw pin levels |
| pin1_i | input | 8 | Group 1 raw pin levels |
| clr_i | input | 1 | Interrupt flag clear pulse |
| mismatch_o | output | 1 | Level mismatch |
| irq_o | output | 1 | Sticky interrupt flag |
| wake_o | output | 1 | Wake request |

## Verification
Directed patterns isolate each group: a difference on a selected pin of group 0 only, then of group 1 only, tells whether each compare and the OR are present. The same difference on a pin that is not selected separates correct masking from a plain compare. Further directed cases probe the synchroniser latency edge by edge, a clear pulse with and without a live mismatch, and the wake-enable gating. Random values for the pins, expected levels and selects then cover mixed cases where only a few masked bits differ, against a model of the formula.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_EXP0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEL0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_EXP1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEL1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  // R6
  sync_two_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q == $past(meta)));
endmodule

// File: rtl/pw_regs.sv
module pw_regs
  import pw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      exp0,
  output logic [W-1:0]      sel0,
  output logic [W-1:0]      exp1,
  output logic [W-1:0]      sel1,
  output logic              wake_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exp0    <= '1;
      sel0    <= '0;
      exp1    <= '1;
      sel1    <= '0;
      wake_en <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_EXP0:  exp0    <= wr_data;
        A_SEL0:  sel0    <= wr_data;
        A_EXP1:  exp1    <= wr_data;
        A_SEL1:  sel1    <= wr_data;
        A_CTRL:  wake_en <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (addr)
        A_EXP0:  rd_data <= exp0;
        A_SEL0:  rd_data <= sel0;
        A_EXP1:  rd_data <= exp1;
        A_SEL1:  rd_data <= sel1;
        A_CTRL:  rd_data <= {{(W-1){1'b0}}, wake_en};
        default: rd_data <= '0;
      endcase
    end
  end

  // R2
  sel0_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SEL0) |=> (sel0 == $past(wr_data)));
  // R2
  exp1_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_EXP1) |=> (exp1 == $past(wr_data)));
  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(exp0) && $stable(sel0) && $stable(exp1)
                && $stable(sel1) && $stable(wake_en)));
endmodule

// File: rtl/pw_detect.sv
module pw_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] s0,
  input  logic [W-1:0] s1,
  input  logic [W-1:0] exp0,
  input  logic [W-1:0] sel0,
  input  logic [W-1:0] exp1,
  input  logic [W-1:0] sel1,
  input  logic         wake_en,
  input  logic         clr,
  output logic         mismatch,
  output logic         wake,
  output logic         flag
);
  logic [W-1:0] diff0;
  logic [W-1:0] diff1;

  always_comb begin
    diff0    = (s0 ^ exp0) & sel0;
    diff1    = (s1 ^ exp1) & sel1;
    mismatch = (|diff0) | (|diff1);
    wake     = mismatch & wake_en;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (mismatch) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R5
  none_selected_chk: assert property (@(posedge clk) disable iff (rst)
    (sel0 == '0 && sel1 == '0) |-> !mismatch);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> flag);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !mismatch) |=> !flag);
  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> (mismatch && wake_en));
endmodule

// File: rtl/pin_watch_top.sv
module pin_watch_top
  import pw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pin0_i,
  input  logic [W-1:0]      pin1_i,
  input  logic              clr_i,
  output logic              mismatch_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int NGRP = 2;

  logic [W-1:0] raw  [NGRP];
  logic [W-1:0] sync [NGRP];
  logic [W-1:0] exp0, sel0, exp1, sel1;
  logic         wake_en;

  assign raw[0] = pin0_i;
  assign raw[1] = pin1_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_sync
    pw_sync #(.W(W)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw[g]),
      .q   (sync[g])
    );
  end

  pw_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .exp0    (exp0),
    .sel0    (sel0),
    .exp1    (exp1),
    .sel1    (sel1),
    .wake_en (wake_en)
  );

  pw_detect #(.W(W)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .s0       (sync[0]),
    .s1       (sync[1]),
    .exp0     (exp0),
    .sel0     (sel0),
    .exp1     (exp1),
    .sel1     (sel1),
    .wake_en  (wake_en),
    .clr      (clr_i),
    .mismatch (mismatch_o),
    .wake     (wake_o),
    .flag     (irq_o)
  );
endmodule

// File: tb/test_pin_watch_top.sv
module test_pin_watch_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] pin0_i, pin1_i;
  logic       clr_i;
  logic       mismatch_o, irq_o, wake_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_watch_top i_pin_watch_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin0_i(pin0_i), .pin1_i(pin1_i), .clr_i(clr_i),
    .mismatch_o(mismatch_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  function automatic logic model_mm(input logic [7:0] p0, input logic [7:0] e0,
                                    input logic [7:0] s0, input logic [7:0] p1,
                                    input logic [7:0] e1, input logic [7:0] s1);
    logic a, b;
    a = 1'b0; b = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (s0[i] && (p0[i] != e0[i])) a = 1'b1;
      if (s1[i] && (p1[i] != e1[i])) b = 1'b1;
    end
    return a || b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pins(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    pin0_i = a; pin1_i = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
    pin0_i = 8'h5A; pin1_i = 8'hC3; clr_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 mismatch", mismatch_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 wake", wake_o, 0);
    rd(3'd0, d); check("R1 exp0", d, 8'hFF);
    rd(3'd1, d); check("R1 sel0", d, 8'h00);
    rd(3'd2, d); check("R1 exp1", d, 8'hFF);
    rd(3'd3, d); check("R1 sel1", d, 8'h00);
    rd(3'd4, d); check("R1 ctrl", d, 8'h00);

    // R2 write/read back
    wr(3'd0, 8'h5A); rd(3'd0, d); check("R2 exp0", d, 8'h5A);
    wr(3'd1, 8'h0F); rd(3'd1, d); check("R2 sel0", d, 8'h0F);
    wr(3'd2, 8'hC3); rd(3'd2, d); check("R2 exp1", d, 8'hC3);
    wr(3'd3, 8'hF0); rd(3'd3, d); check("R2 sel1", d, 8'hF0);

    // R10 control holds bit 0 only, unused addresses
    wr(3'd4, 8'hFF); rd(3'd4, d); check("R10 ctrl bit0 only", d, 8'h01);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'hAA); wr(3'd7, 8'h55);
    rd(3'd5, d); check("R10 addr5 reads zero", d, 8'h00);
    rd(3'd0, d); check("R10 exp0 untouched", d, 8'h5A);
    rd(3'd1, d); check("R10 sel0 untouched", d, 8'h0F);
    rd(3'd3, d); check("R10 sel1 untouched", d, 8'hF0);

    // pins equal expected: no mismatch
    pins(8'h5A, 8'hC3);
    clear_pulse();
    @(negedge clk);
    check("R5 all match", mismatch_o, 0);
    check("R7 irq cleared", irq_o, 0);

    // R5 unselected pins ignored
    pins(8'h5A ^ 8'hF0, 8'hC3 ^ 8'h0F);
    check("R5 unselected ignored", mismatch_o, 0);
    check("R5 irq untouched", irq_o, 0);

    // R6 latency and R3 group 0
    @(negedge clk);
    pin0_i = 8'h5B; pin1_i = 8'hC3;
    @(negedge clk);
    check("R6 one edge no change", mismatch_o, 0);
    @(negedge clk);
    check("R6 two edges mismatch", mismatch_o, 1);
    check("R6 irq not yet", irq_o, 0);
    @(negedge clk);
    check("R6 irq after three", irq_o, 1);
    check("R3 group0 mismatch", mismatch_o, 1);
    check("R9 wake off", wake_o, 0);

    // R8 clear during mismatch
    clear_pulse();
    check("R8 clear with mismatch holds", irq_o, 1);

    // R9 wake enable
    wr(3'd4, 8'h01);
    check("R9 wake on", wake_o, 1);

    // R4 group 1 only
    pins(8'h5A, 8'hC3 ^ 8'h10);
    check("R4 group1 mismatch", mismatch_o, 1);
    check("R9 wake group1", wake_o, 1);

    // R7 sticky then clear
    pins(8'h5A, 8'hC3);
    check("R5 back to match", mismatch_o, 0);
    check("R9 wake follows", wake_o, 0);
    repeat (3) @(negedge clk);
    check("R7 sticky", irq_o, 1);
    clear_pulse();
    check("R7 cleared", irq_o, 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [7:0] e0, s0, e1, s1, p0, p1, flip;
      logic we, m;
      e0 = 8'($urandom); s0 = 8'($urandom); e1 = 8'($urandom); s1 = 8'($urandom);
      flip = (n % 2 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      p0 = e0 ^ (flip & 8'($urandom));
      p1 = e1 ^ (((n % 3) == 0) ? flip : 8'h00);
      we = 1'($urandom);
      wr(3'd0, e0); wr(3'd1, s0); wr(3'd2, e1); wr(3'd3, s1);
      wr(3'd4, {7'd0, we});
      pins(p0, p1);
      m = model_mm(p0, e0, s0, p1, e1, s1);
      check("R3 R4 random mismatch", mismatch_o, m);
      check("R9 random wake", wake_o, m & we);
      clear_pulse();
      check("R8 random flag after clear", irq_o, m);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule